// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block sits next to a processor that reports each bus cycle only as a three-bit status code. It turns that code into separate memory and I/O command strobes, an address latch strobe, and the direction and enable controls for the data transceivers. A cycle opens when the status leaves the passive code (111). The block then steps through a short phase sequence on the system clock. The address strobe comes first. Read, early-write and interrupt-acknowledge commands follow, and the normal write strobe comes one clock after those. Everything releases when the status goes back to passive.

Three inputs shape the outputs. A command enable gates every command strobe. An address enable must be high before memory commands may drive. A bus-mode input picks system-bus or I/O-bus operation. In I/O-bus mode the I/O commands ignore the address enable. The dual-function output follows the bus mode: in system-bus mode it acts as a cascade enable for an interrupt controller, and in I/O-bus mode it enables the I/O transceivers.

Top module: `bus_cmd_gen`

## Requirements
- R1: Status codes decode as follows: 000 interrupt acknowledge (`int_ack`), 001 I/O read (`io_rd`), 010 I/O write (`io_awr`, `io_wr`), 011 halt, 100 code fetch (`mem_rd`), 101 memory read (`mem_rd`), 110 memory write (`mem_awr`, `mem_wr`), 111 passive. At most one command class is active at a time.
- R2: A cycle starts only when the status was 111 at one rising edge and is some other code at the next edge. `ale` is high for exactly the one clock after that second edge, and no command or `den` is active during that clock.
- R3: Read commands, early-write commands (`mem_awr`, `io_awr`) and `int_ack` are active from the second clock of a cycle for as long as the cycle lasts.
- R4: `mem_wr` and `io_wr` are active from the third clock of a cycle, one clock after the matching early write.
- R5: Every command and `den` is low in the clock after an edge that samples status 111, including a cycle that ends after its first clock.
- R6: `den` is active high and is high from the second clock of every cycle except halt. A halt cycle pulses `ale` and drives no command and no `den`.
- R7: `dt_tx` is 1 for write cycles (010, 110) and 0 for all other cycles. It takes its value at the start of a cycle, holds it afterwards, and never changes while `den` is high.
- R8: When `cmd_en` is 0, no command output is high. `ale` and `den` are not affected.
- R9: When `addr_en` is 0, memory commands stay low in both bus modes. In system-bus mode (`io_bus_mode`=0) the I/O commands and `int_ack` also stay low.
- R10: In I/O-bus mode (`io_bus_mode`=1), I/O commands and `int_ack` drive whatever the value of `addr_en`.
- R11: In system-bus mode, `cas_pden` is high for every clock of an interrupt-acknowledge cycle, from `ale` until release. In I/O-bus mode, `cas_pden` is high exactly while `den` is high in I/O and acknowledge cycles.
- R12: A change from one active code to another without passing through 111 starts no new cycle. No `ale` pulses, and the cycle keeps its original type and `dt_tx`.
- R13: While `rst_n` is low at a rising edge, all outputs are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stat_i | input | 3 | Bus status code from the processor |
| cmd_en | input | 1 | Command output enable |
| addr_en | input | 1 | Address enable, allows memory commands |
| io_bus_mode | input | 1 | 1 = I/O-bus mode, 0 = system-bus mode |
| ale | output | 1 | Address latch strobe |
| den | output | 1 | Data transceiver enable, active high |
| dt_tx | output | 1 | Transceiver direction, 1 = transmit |
| cas_pden | output | 1 | Cascade enable (system-bus) or I/O transceiver enable (I/O-bus) |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| mem_awr | output | 1 | Early memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| io_awr | output | 1 | Early I/O write command |
| int_ack | output | 1 | Interrupt acknowledge command |

## Verification
The hardest case to reach from the ports is a status that moves straight from one active code to another in the middle of a cycle. A normal processor always passes through passive between cycles, so this never happens in ordinary traffic. The bench forces it by opening a memory read and then, with no passive clock in between, switching the status to a write code and then an I/O code. It then confirms that `ale` stays low and that both the command and `dt_tx` still reflect the original read. A second hard case is a cycle cut short after its address clock. The bench reaches it by returning the status to passive right after `ale` is seen.

// File: rtl/bcg_pkg.sv
// Package: shared types for the bus command generator.
// Assumes a three-bit status code with a fixed encoding.
package bcg_pkg;
    localparam int STAT_W = 3;

    typedef enum logic [STAT_W-1:0] {
        ST_ACK     = 3'b000,
        ST_IORD    = 3'b001,
        ST_IOWR    = 3'b010,
        ST_HALT    = 3'b011,
        ST_FETCH   = 3'b100,
        ST_MEMRD   = 3'b101,
        ST_MEMWR   = 3'b110,
        ST_PASSIVE = 3'b111
    } bus_stat_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_CMD  = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    typedef struct packed {
        logic mem;
        logic io;
        logic ack;
        logic rd;
        logic wr;
        logic halt;
    } cyc_kind_t;
endpackage

// File: rtl/bcg_status_decode.sv
// Module: bcg_status_decode
// Turns a raw status code into cycle-class flags.
// Purely combinational. A passive code yields all-zero flags.
module bcg_status_decode
    import bcg_pkg::*;
(
    input  logic [STAT_W-1:0] stat,
    output cyc_kind_t         kind,
    output logic              passive
);
    // classify the incoming status code
    always_comb begin
        kind    = '0;
        passive = 1'b0;
        case (bus_stat_e'(stat))
            ST_ACK:   begin kind.ack = 1'b1; kind.rd = 1'b1; end
            ST_IORD:  begin kind.io  = 1'b1; kind.rd = 1'b1; end
            ST_IOWR:  begin kind.io  = 1'b1; kind.wr = 1'b1; end
            ST_HALT:  kind.halt = 1'b1;
            ST_FETCH: begin kind.mem = 1'b1; kind.rd = 1'b1; end
            ST_MEMRD: begin kind.mem = 1'b1; kind.rd = 1'b1; end
            ST_MEMWR: begin kind.mem = 1'b1; kind.wr = 1'b1; end
            default:  passive = 1'b1;
        endcase
    end
endmodule

// File: rtl/bcg_sequencer.sv
// Module: bcg_sequencer
// Tracks the bus-cycle phase. A cycle starts on a passive-to-active
// edge of the status, and the cycle type is latched at that edge.
// Assumes the status inputs are synchronous to clk.
module bcg_sequencer
    import bcg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cyc_kind_t kind_now,
    input  logic      passive_now,
    output phase_e    phase,
    output cyc_kind_t kind_q,
    output logic      dt_tx
);
    logic   was_passive;
    logic   start;

    // a new cycle needs passive at the previous edge and active now
    assign start = was_passive && !passive_now;

    // remember whether the previous sampled status was passive
    always_ff @(posedge clk) begin
        if (!rst_n) was_passive <= 1'b1;
        else        was_passive <= passive_now;
    end

    // phase progression: idle -> addr -> cmd -> data, exit on passive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: if (start) phase <= PH_ADDR;
                PH_ADDR: phase <= passive_now ? PH_IDLE : PH_CMD;
                PH_CMD:  phase <= passive_now ? PH_IDLE : PH_DATA;
                default: phase <= passive_now ? PH_IDLE : PH_DATA;
            endcase
        end
    end

    // latch cycle type and direction only at a cycle start (den low)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= '0;
            dt_tx  <= 1'b0;
        end else if (phase == PH_IDLE && start) begin
            kind_q <= kind_now;
            dt_tx  <= kind_now.wr;
        end
    end
endmodule

// File: rtl/bcg_cmd_gate.sv
// Module: bcg_cmd_gate
// Forms the strobes from the phase and the latched cycle type, then
// applies the command, address and bus-mode enables. Combinational.
module bcg_cmd_gate
    import bcg_pkg::*;
(
    input  phase_e    phase,
    input  cyc_kind_t kind_q,
    input  logic      cmd_en,
    input  logic      addr_en,
    input  logic      io_bus_mode,
    output logic      ale,
    output logic      den,
    output logic      cas_pden,
    output logic      mem_rd,
    output logic      mem_wr,
    output logic      mem_awr,
    output logic      io_rd,
    output logic      io_wr,
    output logic      io_awr,
    output logic      int_ack
);
    logic early, late, mem_ok, io_ok, in_cycle;

    // phase windows
    assign in_cycle = (phase != PH_IDLE);
    assign early    = (phase == PH_CMD) || (phase == PH_DATA);
    assign late     = (phase == PH_DATA);

    // enable qualifiers per command class
    assign mem_ok = cmd_en && addr_en;
    assign io_ok  = cmd_en && (io_bus_mode || addr_en);

    // ungated timing outputs
    assign ale = (phase == PH_ADDR);
    assign den = early && (kind_q.mem || kind_q.io || kind_q.ack);

    // memory command strobes
    always_comb begin
        mem_rd  = mem_ok && early && kind_q.mem && kind_q.rd;
        mem_awr = mem_ok && early && kind_q.mem && kind_q.wr;
        mem_wr  = mem_ok && late  && kind_q.mem && kind_q.wr;
    end

    // I/O and acknowledge command strobes
    always_comb begin
        io_rd   = io_ok && early && kind_q.io && kind_q.rd;
        io_awr  = io_ok && early && kind_q.io && kind_q.wr;
        io_wr   = io_ok && late  && kind_q.io && kind_q.wr;
        int_ack = io_ok && early && kind_q.ack;
    end

    // dual-function output follows the bus mode
    always_comb begin
        if (io_bus_mode) cas_pden = den && (kind_q.io || kind_q.ack);
        else             cas_pden = in_cycle && kind_q.ack;
    end
endmodule

// File: rtl/bus_cmd_gen.sv
// Module: bus_cmd_gen (top)
// Status-decoded bus command generator: decode, phase sequencing and
// output gating. All outputs are active high. Reset is synchronous, active low.
module bus_cmd_gen
    import bcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_i,
    input  logic              cmd_en,
    input  logic              addr_en,
    input  logic              io_bus_mode,
    output logic              ale,
    output logic              den,
    output logic              dt_tx,
    output logic              cas_pden,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_awr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              io_awr,
    output logic              int_ack
);
    cyc_kind_t kind_now, kind_q;
    logic      passive_now;
    phase_e    phase;

    bcg_status_decode u_dec (
        .stat    (stat_i),
        .kind    (kind_now),
        .passive (passive_now)
    );

    bcg_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind_now    (kind_now),
        .passive_now (passive_now),
        .phase       (phase),
        .kind_q      (kind_q),
        .dt_tx       (dt_tx)
    );

    bcg_cmd_gate u_gate (
        .phase       (phase),
        .kind_q      (kind_q),
        .cmd_en      (cmd_en),
        .addr_en     (addr_en),
        .io_bus_mode (io_bus_mode),
        .ale         (ale),
        .den         (den),
        .cas_pden    (cas_pden),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .mem_awr     (mem_awr),
        .io_rd       (io_rd),
        .io_wr       (io_wr),
        .io_awr      (io_awr),
        .int_ack     (int_ack)
    );
endmodule

// File: rtl/bcg_checker.sv
// Module: bcg_checker
// Temporal checks on the ports of bus_cmd_gen. Attached by bind.
module bcg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] stat_i,
    input logic       cmd_en,
    input logic       addr_en,
    input logic       io_bus_mode,
    input logic       ale,
    input logic       den,
    input logic       dt_tx,
    input logic       cas_pden,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       mem_awr,
    input logic       io_rd,
    input logic       io_wr,
    input logic       io_awr,
    input logic       int_ack
);
    logic seen1, seen2;
    logic any_mem, any_io, any_cmd;

    assign any_mem = mem_rd || mem_wr || mem_awr;
    assign any_io  = io_rd || io_wr || io_awr || int_ack;
    assign any_cmd = any_mem || any_io;

    // count clocks since reset so $past never reaches before it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen1 <= 1'b0;
            seen2 <= 1'b0;
        end else begin
            seen1 <= 1'b1;
            seen2 <= seen1;
        end
    end

    assert_one_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd || mem_awr || mem_wr, io_rd || io_awr || io_wr, int_ack}));

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_ale_after_passive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen2 && ale) |-> ($past(stat_i, 2) == 3'b111 && $past(stat_i) != 3'b111));

    assert_write_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen1 && (mem_wr || io_wr)) |-> (!ale && $past(den)));

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen1 && $past(stat_i) == 3'b111) |-> (!den && !any_cmd));

    assert_den_not_ale_R6: assert property (@(posedge clk) disable iff (!rst_n)
        den |-> !ale);

    assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen1 && den && $past(den)) |-> $stable(dt_tx));

    assert_cmd_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_en |-> !any_cmd);

    assert_mem_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_en |-> !any_mem);

    assert_io_gate_sys_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_en && !io_bus_mode) |-> !any_io);
endmodule

bind bus_cmd_gen bcg_checker u_bcg_checker (.*);

// File: tb/tb_bus_cmd_gen.sv
// Directed bench for bus_cmd_gen: one task per scenario.
module tb_bus_cmd_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] stat_i;
    logic       cmd_en, addr_en, io_bus_mode;
    logic       ale, den, dt_tx, cas_pden;
    logic       mem_rd, mem_wr, mem_awr, io_rd, io_wr, io_awr, int_ack;

    int n_checks = 0;
    int n_fail   = 0;
    logic exp_dt = 1'b0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    bus_cmd_gen dut (
        .clk(clk), .rst_n(rst_n), .stat_i(stat_i), .cmd_en(cmd_en),
        .addr_en(addr_en), .io_bus_mode(io_bus_mode), .ale(ale), .den(den),
        .dt_tx(dt_tx), .cas_pden(cas_pden), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_awr(mem_awr), .io_rd(io_rd), .io_wr(io_wr), .io_awr(io_awr),
        .int_ack(int_ack)
    );

    // output vector: ale den dt cas mem_rd mem_wr mem_awr io_rd io_wr io_awr int_ack
    function automatic logic [10:0] outs();
        return {ale, den, dt_tx, cas_pden, mem_rd, mem_wr, mem_awr,
                io_rd, io_wr, io_awr, int_ack};
    endfunction

    // expected outputs from the requirements; ph 0 idle, 1 first clock, 2 second, 3 later
    function automatic logic [10:0] expect_v(input logic [2:0] code, input int ph,
                                             input logic dt);
        logic is_mem, is_io, is_ack, is_wr, is_rd, mem_ok, io_ok, e, l, d, c;
        is_mem = (code == 3'b100) || (code == 3'b101) || (code == 3'b110);
        is_io  = (code == 3'b001) || (code == 3'b010);
        is_ack = (code == 3'b000);
        is_wr  = (code == 3'b010) || (code == 3'b110);
        is_rd  = (code == 3'b001) || (code == 3'b100) || (code == 3'b101);
        mem_ok = cmd_en && addr_en;
        io_ok  = cmd_en && (io_bus_mode || addr_en);
        e = (ph >= 2);
        l = (ph == 3);
        d = e && (is_mem || is_io || is_ack);
        c = io_bus_mode ? (d && (is_io || is_ack)) : ((ph >= 1) && is_ack);
        return {ph == 1, d, dt, c,
                mem_ok && e && is_mem && is_rd,
                mem_ok && l && is_mem && is_wr,
                mem_ok && e && is_mem && is_wr,
                io_ok && e && is_io && is_rd,
                io_ok && l && is_io && is_wr,
                io_ok && e && is_io && is_wr,
                io_ok && e && is_ack};
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input logic [10:0] act, input logic [10:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // full cycle: passive, code for `hold` clocks, passive; checks every phase
    task automatic run_cycle(input logic [2:0] code, input int hold, input string tag);
        stat_i = 3'b111;
        step();
        stat_i = code;
        exp_dt = (code == 3'b010) || (code == 3'b110);
        for (int i = 1; i <= hold; i++) begin
            step();
            check(outs(), expect_v(code, (i > 3) ? 3 : i, exp_dt),
                  $sformatf("%s clk%0d code=%b", tag, i, code));
        end
        stat_i = 3'b111;
        step();
        check(outs(), expect_v(code, 0, exp_dt), $sformatf("%s release R5 code=%b", tag, code));
    endtask

    task automatic set_en(input logic c, input logic a, input logic m);
        cmd_en = c; addr_en = a; io_bus_mode = m;
    endtask

    // R13: reset state
    task automatic t_reset();
        rst_n = 1'b0; stat_i = 3'b010; set_en(1, 1, 0);
        step(); step();
        check(outs(), 11'b0, "R13 reset outputs");
        stat_i = 3'b111;
        step();
        rst_n = 1'b1;
        step();
    endtask

    // R1 R2 R3 R4 R6 R7: every code with all enables, system-bus mode
    task automatic t_all_codes();
        set_en(1, 1, 0);
        for (int k = 0; k < 7; k++) run_cycle(k[2:0], 4, "R1/R2/R3/R4/R6/R7");
    endtask

    // R7: direction changes back to receive at the start of a read after a write
    task automatic t_direction();
        set_en(1, 1, 0);
        run_cycle(3'b110, 3, "R7 write");
        check({2'b0, dt_tx, 8'b0}, {2'b0, 1'b1, 8'b0}, "R7 dt held after write");
        run_cycle(3'b101, 3, "R7 read");
        check({2'b0, dt_tx, 8'b0}, 11'b0, "R7 dt receive after read");
    endtask

    // R5: a cycle cut short after the address clock
    task automatic t_short();
        set_en(1, 1, 0);
        run_cycle(3'b101, 1, "R5 short");
        run_cycle(3'b010, 2, "R5 two-clock");
    endtask

    // R8: command enable low
    task automatic t_cmd_gate();
        set_en(0, 1, 0);
        run_cycle(3'b110, 3, "R8 memwr");
        run_cycle(3'b001, 3, "R8 iord");
        run_cycle(3'b000, 3, "R8 ack");
    endtask

    // R9: address enable low in system-bus mode
    task automatic t_addr_gate();
        set_en(1, 0, 0);
        run_cycle(3'b101, 3, "R9 memrd");
        run_cycle(3'b010, 3, "R9 iowr");
        run_cycle(3'b000, 3, "R9 ack");
    endtask

    // R10: I/O-bus mode ignores the address enable for I/O commands
    task automatic t_io_mode();
        set_en(1, 0, 1);
        run_cycle(3'b001, 3, "R10 iord");
        run_cycle(3'b010, 3, "R10 iowr");
        run_cycle(3'b110, 3, "R10/R9 memwr blocked");
    endtask

    // R11: the dual-function output in both bus modes
    task automatic t_cas_pden();
        set_en(1, 1, 0);
        run_cycle(3'b000, 3, "R11 sys ack");
        run_cycle(3'b001, 3, "R11 sys io");
        set_en(1, 1, 1);
        run_cycle(3'b010, 3, "R11 iobus iowr");
        run_cycle(3'b000, 3, "R11 iobus ack");
        run_cycle(3'b101, 3, "R11 iobus memrd");
    endtask

    // R12: active-to-active change without passive keeps the cycle
    task automatic t_no_restart();
        set_en(1, 1, 0);
        stat_i = 3'b111;
        step();
        stat_i = 3'b101;
        exp_dt = 1'b0;
        step();
        check(outs(), expect_v(3'b101, 1, 1'b0), "R12 first clock");
        step();
        check(outs(), expect_v(3'b101, 2, 1'b0), "R12 second clock");
        stat_i = 3'b110;
        step();
        check(outs(), expect_v(3'b101, 3, 1'b0), "R12 after switch to write");
        stat_i = 3'b010;
        step();
        check(outs(), expect_v(3'b101, 3, 1'b0), "R12 after switch to io");
        stat_i = 3'b111;
        step();
        check(outs(), expect_v(3'b101, 0, 1'b0), "R12 release");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_all_codes();
        t_direction();
        t_short();
        t_cmd_gate();
        t_addr_gate();
        t_io_mode();
        t_cas_pden();
        t_no_restart();
        finish_run();
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule